// File: doc/BRIEF.md
# Trigger Overrun Error Monitor

The monitor sits between a bank of trigger sources and the subunits they start, such as ADC command generators. Each subunit reports whether it is busy. A trigger that reaches an idle subunit is passed on. A trigger that reaches a busy subunit is an overrun: the subunit keeps working on its current job, the trigger is dropped, and an error is recorded. The command generator can also report an invalid command with a one-cycle pulse. The monitor records that pulse as a separate error.

Every error source has a sticky bit in a flag vector. All the bits drive one shared interrupt line. Software enables that line with a single enable bit. After an interrupt, software reads the flag vector to find which source raised it, then clears the bits it has handled by writing ones to them.

Top module: `trig_err_mon`

## Requirements
- R1: While rst_ni is low, and directly after reset is released, flags_o is all zero, the enable bit is 0 and irq_o is 0.
- R2: If trig_i[i] and busy_i[i] are both high at a rising clock edge, flags_o[i] is 1 after that edge.
- R3: If trig_i[i] is high and busy_i[i] is low, trig_fwd_o[i] is high in the same cycle and flags_o[i] is not set by that trigger.
- R4: If trig_i[i] is high while busy_i[i] is high, trig_fwd_o[i] stays low, so the trigger is dropped.
- R5: A high inv_cmd_i at a rising edge sets flags_o[N_SUB], the top bit, after that edge.
- R6: A set flag bit stays set until software clears it, whatever the later trigger, busy and command inputs do.
- R7: When clr_we_i is high at an edge, each flag bit whose clr_mask_i bit is 1 is cleared. Bits whose mask bit is 0 are left as they are.
- R8: If a bit's error event and its clear happen at the same edge, the bit is 1 after that edge.
- R9: irq_o equals the enable bit ANDed with the OR of all flag bits.
- R10: When ie_we_i is high at an edge, the enable bit takes the value of ie_wdata_i. While the enable bit is 0, irq_o stays 0 even when flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | N_SUB | Trigger request, one bit per subunit |
| busy_i | input | N_SUB | Busy status, one bit per subunit |
| inv_cmd_i | input | 1 | Invalid-command pulse from the command generator |
| trig_fwd_o | output | N_SUB | Trigger passed to an idle subunit |
| clr_we_i | input | 1 | Write strobe for the flag clear |
| clr_mask_i | input | N_SUB+1 | Write-one-to-clear mask for the flags |
| ie_we_i | input | 1 | Write strobe for the enable bit |
| ie_wdata_i | input | 1 | New value of the enable bit |
| flags_o | output | N_SUB+1 | Sticky error flags: bits [N_SUB-1:0] are overruns, bit N_SUB is invalid command |
| irq_o | output | 1 | Shared error interrupt |

## Verification
The assertions assume that the inputs are synchronous to clk_i and do not change between edges. They also assume that a single-cycle inv_cmd_i pulse marks one event. The bench changes every input only on the falling edge, so the inputs are stable at each rising edge. It drives busy_i on its own, separately from trig_i, so that triggers land on idle and on busy subunits in every combination. It also lines up error events with clears and with enable writes on purpose, so that the set-wins case and the enable gating both occur.

// File: rtl/trig_err_pkg.sv
package trig_err_pkg;
  typedef enum logic [0:0] {
    IRQ_OFF = 1'b0,
    IRQ_ON  = 1'b1
  } irq_en_e;
endpackage

// File: rtl/trig_gate.sv
module trig_gate #(
  parameter int unsigned N_SUB = 4
) (
  input  logic [N_SUB-1:0] trig_i,
  input  logic [N_SUB-1:0] busy_i,
  output logic [N_SUB-1:0] fwd_o,
  output logic [N_SUB-1:0] ovr_o
);
  for (genvar i = 0; i < N_SUB; i++) begin : g_lane
    assign fwd_o[i] = trig_i[i] & ~busy_i[i];
    assign ovr_o[i] = trig_i[i] &  busy_i[i];
  end
endmodule

// File: rtl/err_flag_reg.sv
module err_flag_reg #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;

  // set dominates clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import trig_err_pkg::*;
#(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ie_we_i,
  input  logic         ie_wdata_i,
  input  logic [W-1:0] flags_i,
  output logic         irq_o
);
  irq_en_e ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ie_q <= IRQ_OFF;
    else if (ie_we_i) ie_q <= irq_en_e'(ie_wdata_i);
  end

  assign irq_o = (ie_q == IRQ_ON) && (|flags_i);
endmodule

// File: rtl/trig_err_mon.sv
module trig_err_mon #(
  parameter int unsigned N_SUB = 4,
  localparam int unsigned NFLAG = N_SUB + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SUB-1:0] trig_i,
  input  logic [N_SUB-1:0] busy_i,
  input  logic             inv_cmd_i,
  output logic [N_SUB-1:0] trig_fwd_o,
  input  logic             clr_we_i,
  input  logic [NFLAG-1:0] clr_mask_i,
  input  logic             ie_we_i,
  input  logic             ie_wdata_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  logic [N_SUB-1:0] ovr;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;

  trig_gate #(.N_SUB(N_SUB)) u_gate (
    .trig_i (trig_i),
    .busy_i (busy_i),
    .fwd_o  (trig_fwd_o),
    .ovr_o  (ovr)
  );

  assign set_vec = {inv_cmd_i, ovr};
  assign clr_vec = clr_we_i ? clr_mask_i : '0;

  err_flag_reg #(.W(NFLAG)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags_o)
  );

  irq_ctrl #(.W(NFLAG)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ie_we_i    (ie_we_i),
    .ie_wdata_i (ie_wdata_i),
    .flags_i    (flags_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/trig_err_mon_chk.sv
module trig_err_mon_chk #(
  parameter int unsigned N_SUB = 4,
  localparam int unsigned NFLAG = N_SUB + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SUB-1:0] trig_i,
  input logic [N_SUB-1:0] busy_i,
  input logic             inv_cmd_i,
  input logic [N_SUB-1:0] trig_fwd_o,
  input logic             clr_we_i,
  input logic [NFLAG-1:0] clr_mask_i,
  input logic             ie_we_i,
  input logic             ie_wdata_i,
  input logic [NFLAG-1:0] flags_o,
  input logic             irq_o
);
  logic [NFLAG-1:0] clr_eff;
  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  // R2
  overrun_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_o[N_SUB-1:0] & $past(trig_i & busy_i)) == $past(trig_i & busy_i)));

  // R4
  no_fwd_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_fwd_o & busy_i) == '0);

  // R5
  inv_cmd_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_cmd_i |=> flags_o[N_SUB]);

  // R6
  flag_falls_only_on_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flags_o) & ~flags_o & ~$past(clr_eff)) == '0));

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags_o != '0));

  // R10
  irq_off_after_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_we_i && !ie_wdata_i) |=> !irq_o);
endmodule

bind trig_err_mon trig_err_mon_chk #(.N_SUB(N_SUB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trig_i     (trig_i),
  .busy_i     (busy_i),
  .inv_cmd_i  (inv_cmd_i),
  .trig_fwd_o (trig_fwd_o),
  .clr_we_i   (clr_we_i),
  .clr_mask_i (clr_mask_i),
  .ie_we_i    (ie_we_i),
  .ie_wdata_i (ie_wdata_i),
  .flags_o    (flags_o),
  .irq_o      (irq_o)
);

// File: tb/sim_trig_err_mon.sv
module sim_trig_err_mon;
  localparam int unsigned N_SUB = 4;
  localparam int unsigned NFLAG = N_SUB + 1;
  localparam time CLK_PERIOD = 10ns;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_SUB-1:0] trig_i = '0;
  logic [N_SUB-1:0] busy_i = '0;
  logic             inv_cmd_i = 1'b0;
  logic [N_SUB-1:0] trig_fwd_o;
  logic             clr_we_i = 1'b0;
  logic [NFLAG-1:0] clr_mask_i = '0;
  logic             ie_we_i = 1'b0;
  logic             ie_wdata_i = 1'b0;
  logic [NFLAG-1:0] flags_o;
  logic             irq_o;

  int n_run = 0;
  int n_fail = 0;
  logic [NFLAG-1:0] flags_m = '0;
  logic             ie_m = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  trig_err_mon #(.N_SUB(N_SUB)) u0 (
    .clk_i, .rst_ni, .trig_i, .busy_i, .inv_cmd_i, .trig_fwd_o,
    .clr_we_i, .clr_mask_i, .ie_we_i, .ie_wdata_i, .flags_o, .irq_o
  );

  function automatic logic [NFLAG-1:0] next_flags(logic [NFLAG-1:0] f,
      logic [N_SUB-1:0] t, logic [N_SUB-1:0] b, logic inv,
      logic cwe, logic [NFLAG-1:0] cm);
    logic [NFLAG-1:0] clr;
    clr = cwe ? cm : '0;
    return (f & ~clr) | {inv, t & b};
  endfunction

  function automatic logic exp_irq(logic ie, logic [NFLAG-1:0] f);
    return ie & (|f);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // apply inputs at negedge, check fwd, clock, update model, check state
  task automatic step(logic [N_SUB-1:0] t, logic [N_SUB-1:0] b, logic inv,
                      logic cwe, logic [NFLAG-1:0] cm, logic iwe, logic iwd);
    trig_i = t; busy_i = b; inv_cmd_i = inv;
    clr_we_i = cwe; clr_mask_i = cm; ie_we_i = iwe; ie_wdata_i = iwd;
    #1;
    check("R3/R4 fwd", 32'(trig_fwd_o), 32'(t & ~b));
    @(posedge clk_i);
    flags_m = next_flags(flags_m, t, b, inv, cwe, cm);
    if (iwe) ie_m = iwd;
    @(negedge clk_i);
    check("R2/R5/R6/R7/R8 flags", 32'(flags_o), 32'(flags_m));
    check("R9/R10 irq", 32'(irq_o), 32'(exp_irq(ie_m, flags_m)));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 during reset, with inputs that would set flags
    trig_i = '1; busy_i = '1; inv_cmd_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 flags in reset", 32'(flags_o), 0);
    check("R1 irq in reset", 32'(irq_o), 0);
    trig_i = '0; busy_i = '0; inv_cmd_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 flags after reset", 32'(flags_o), 0);

    // R3 forward on idle subunits, no flag
    step(4'b0101, 4'b0000, 0, 0, '0, 0, 0);
    check("R3 no flag on idle", 32'(flags_o), 0);
    // R2 R4 overrun on lane 1
    step(4'b0010, 4'b0010, 0, 0, '0, 0, 0);
    check("R2 lane1 set", 32'(flags_o[1]), 1);
    // R9 R10: enable off -> irq 0 although flag set
    check("R10 irq gated", 32'(irq_o), 0);
    step('0, '0, 0, 0, '0, 1, 1);
    check("R9 irq on", 32'(irq_o), 1);
    // R5 invalid command
    step('0, '0, 1, 0, '0, 0, 0);
    check("R5 inv flag", 32'(flags_o[N_SUB]), 1);
    // R6 sticky through idle cycles
    repeat (3) step('0, 4'b1111, 0, 0, '0, 0, 0);
    check("R6 sticky", 32'(flags_o), 32'h12);
    // R7 partial clear: clear bit 1 only
    step('0, '0, 0, 1, 5'b00010, 0, 0);
    check("R7 partial clear", 32'(flags_o), 32'h10);
    // R8 set wins over clear on bit 3
    step(4'b1000, 4'b1000, 0, 1, 5'b01000, 0, 0);
    check("R8 set wins", 32'(flags_o[3]), 1);
    // R7 clear all, irq drops
    step('0, '0, 0, 1, '1, 0, 0);
    check("R7 clear all", 32'(flags_o), 0);
    check("R9 irq off when no flags", 32'(irq_o), 0);
    // R10 disable with flag present
    step(4'b0001, 4'b0001, 0, 0, '0, 1, 0);
    check("R10 disabled irq", 32'(irq_o), 0);
    step('0, '0, 0, 0, '0, 1, 1);
    check("R10 re-enabled irq", 32'(irq_o), 1);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [N_SUB-1:0] t, b;
      logic [NFLAG-1:0] cm;
      logic inv, cwe, iwe, iwd;
      t = N_SUB'($urandom) & N_SUB'($urandom);
      b = N_SUB'($urandom);
      inv = ($urandom % 8) == 0;
      cwe = ($urandom % 4) == 0;
      cm = NFLAG'($urandom);
      iwe = ($urandom % 16) == 0;
      iwd = 1'($urandom);
      step(t, b, inv, cwe, cm, iwe, iwd);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule